// File: doc/BRIEF.md
# Dual-Function Bridge Configuration Register File

This block holds the byte-wide configuration space of a bridge device that exposes two functions: a host-bridge function (function 0) and a PCI-to-PCI bridge function (function 1). Each function owns 256 bytes. A requester presents a function number, an 8-bit byte address, a write strobe and a data byte. Writes commit on the next clock edge. The read byte comes out of a register one cycle after the address is presented.

Writes do not reach a plain RAM. A per-function write policy drops writes to read-only address ranges. It applies bit masks to the command byte and gives the status byte write-one-to-clear behaviour. It forces the low nibble of address-window registers to zero. Two event inputs, one per function, set status bits so that the clear path has something to act on. The three host-function bytes that steer the legacy memory decoder's shadowing are brought out as dedicated outputs.

Top module: `bcfg_regfile`

## Requirements
- R1: A read with a function number other than 0 or 1 returns 0xFF. A write with such a function number changes no byte of either function.
- R2: In function 0, writes are dropped at addresses 0x00–0x03, 0x05–0x06, 0x08–0x0C, 0x0E–0x11, 0x14–0x4F, 0x79–0x7D, 0x85–0x87, 0x8C–0xA7 and 0xAD–0xFC.
- R3: In function 1, writes are dropped at addresses 0x00–0x03, 0x05–0x06, 0x08–0x17, 0x1B, 0x1E–0x1F, 0x28–0x3D and 0x43–0xFF.
- R4: At the command byte 0x04, a write changes only bit 6 in function 0 and only the bits of mask 0x47 in function 1. All other bits keep their value, which is 0.
- R5: The status byte 0x07 holds only the bits of mask 0xB0 (function 0) or 0x30 (function 1). A status-set input bit inside the mask sets that bit. Writing 1 to a masked bit clears it, and writing 0 leaves it unchanged. If a set and a clear of the same bit arrive in the same cycle, the set wins.
- R6: Writes to function 0 byte 0x12 and to function 1 bytes 0x20, 0x22, 0x24 and 0x26 store the data with its low nibble forced to 0. Function 0 byte 0x13 and function 1 byte 0x21 store the full byte.
- R7: After reset, function 1 byte 0x25 reads 0xFF and every other byte of both functions reads 0x00.
- R8: The read output is registered. It shows the byte stored at the address presented before the clock edge. When a write to that same byte happens in the same cycle, the output shows the value from before the write.
- R9: The three shadow-control outputs equal function 0 bytes 0x61, 0x62 and 0x63. They take a written value on the clock edge that commits the write.
- R10: Any address that R2–R6 do not restrict stores the full written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_func | input | 3 | Function number of the access |
| cfg_addr | input | 8 | Byte address within the function |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data byte |
| host_sts_set | input | 8 | Status-set events for function 0 (bits outside 0xB0 ignored) |
| p2p_sts_set | input | 8 | Status-set events for function 1 (bits outside 0x30 ignored) |
| cfg_rdata | output | 8 | Registered read byte |
| shadow_ctl0 | output | 8 | Function 0 byte 0x61 |
| shadow_ctl1 | output | 8 | Function 0 byte 0x62 |
| shadow_ctl2 | output | 8 | Function 0 byte 0x63 |

## Verification
The properties assume that function and address inputs are known at every clock edge after reset. They also assume that status-set inputs are the only route into the status byte. With those inputs, the command, status and window bytes can never read back with forbidden bits set, whatever the access pattern. The bench drives every input at the falling edge and holds idle values between scenarios. It raises a status-set input only for a single cycle inside its own task, so every read it checks sees fully settled state.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

   localparam int unsigned CFG_AW = 8;
   localparam int unsigned CFG_DW = 8;

   typedef logic [CFG_AW-1:0] addr_t;
   typedef logic [CFG_DW-1:0] byte_t;

   // fixed byte locations whose behaviour other logic depends on
   localparam addr_t A_CMD       = 8'h04;
   localparam addr_t A_STS       = 8'h07;
   localparam addr_t A_APER      = 8'h12;
   localparam addr_t A_MEM_BASE  = 8'h20;
   localparam addr_t A_MEM_LIM   = 8'h22;
   localparam addr_t A_PF_BASE   = 8'h24;
   localparam addr_t A_PF_LIM    = 8'h26;
   localparam addr_t A_PF_HI_ONE = 8'h25;
   localparam addr_t A_SHD0      = 8'h61;
   localparam addr_t A_SHD1      = 8'h62;
   localparam addr_t A_SHD2      = 8'h63;

   localparam byte_t HOST_CMD_MASK = 8'h40;
   localparam byte_t P2P_CMD_MASK  = 8'h47;
   localparam byte_t HOST_W1C_MASK = 8'hB0;
   localparam byte_t P2P_W1C_MASK  = 8'h30;
   localparam byte_t NIB_KEEP      = 8'hF0;

   localparam int unsigned NUM_SHADOW = 3;

   typedef enum logic [1:0] {
      WK_PLAIN,
      WK_MASKED,
      WK_W1C,
      WK_HINIB
   } wr_kind_e;

   function automatic logic host_read_only(addr_t a);
      return (a < 8'h04) ||
             (a inside {[8'h05:8'h06]}) ||
             (a inside {[8'h08:8'h0C]}) ||
             (a inside {[8'h0E:8'h11]}) ||
             (a inside {[8'h14:8'h4F]}) ||
             (a inside {[8'h79:8'h7D]}) ||
             (a inside {[8'h85:8'h87]}) ||
             (a inside {[8'h8C:8'hA7]}) ||
             (a inside {[8'hAD:8'hFC]});
   endfunction

   function automatic logic p2p_read_only(addr_t a);
      return (a < 8'h04) ||
             (a inside {[8'h05:8'h06]}) ||
             (a inside {[8'h08:8'h17]}) ||
             (a == 8'h1B) ||
             (a inside {[8'h1E:8'h1F]}) ||
             (a inside {[8'h28:8'h3D]}) ||
             (a >= 8'h43);
   endfunction

   function automatic wr_kind_e host_kind(addr_t a);
      if (a == A_CMD)  return WK_MASKED;
      if (a == A_STS)  return WK_W1C;
      if (a == A_APER) return WK_HINIB;
      return WK_PLAIN;
   endfunction

   function automatic wr_kind_e p2p_kind(addr_t a);
      if (a == A_CMD) return WK_MASKED;
      if (a == A_STS) return WK_W1C;
      if (a inside {A_MEM_BASE, A_MEM_LIM, A_PF_BASE, A_PF_LIM}) return WK_HINIB;
      return WK_PLAIN;
   endfunction

   function automatic byte_t apply_kind(wr_kind_e k, byte_t cur, byte_t wd, byte_t mask);
      unique case (k)
         WK_MASKED: return (cur & ~mask) | (wd & mask);
         WK_W1C:    return cur & ~(wd & mask);
         WK_HINIB:  return wd & NIB_KEEP;
         default:   return wd;
      endcase
   endfunction

   function automatic byte_t reset_value(int unsigned func_id, addr_t a);
      if ((func_id == 1) && (a == A_PF_HI_ONE)) return 8'hFF;
      return 8'h00;
   endfunction

endpackage

// File: rtl/bcfg_wpolicy.sv
module bcfg_wpolicy
   import bcfg_pkg::*;
#(
   parameter int unsigned FUNC_ID = 0
) (
   input  addr_t addr,
   input  byte_t cur_byte,
   input  byte_t wdata,
   output logic  wr_ok,
   output byte_t next_byte
);

   wr_kind_e kind;
   byte_t    mask;

   generate
      if (FUNC_ID == 0) begin : g_host
         always_comb begin
            wr_ok = !host_read_only(addr);
            kind  = host_kind(addr);
            mask  = (kind == WK_W1C) ? HOST_W1C_MASK : HOST_CMD_MASK;
         end
      end else if (FUNC_ID == 1) begin : g_p2p
         always_comb begin
            wr_ok = !p2p_read_only(addr);
            kind  = p2p_kind(addr);
            mask  = (kind == WK_W1C) ? P2P_W1C_MASK : P2P_CMD_MASK;
         end
      end else begin : g_bad
         $error("bcfg_wpolicy: FUNC_ID must be 0 or 1");
      end
   endgenerate

   assign next_byte = apply_kind(kind, cur_byte, wdata, mask);

endmodule

// File: rtl/bcfg_bank.sv
module bcfg_bank
   import bcfg_pkg::*;
#(
   parameter int unsigned FUNC_ID = 0,
   parameter int unsigned AW      = CFG_AW,
   parameter int unsigned DW      = CFG_DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] sts_set,
   output logic [DW-1:0] rd_byte,
   output logic [DW-1:0] shadow [NUM_SHADOW]
);

   localparam int unsigned DEPTH    = 1 << AW;
   localparam byte_t       W1C_MASK = (FUNC_ID == 0) ? HOST_W1C_MASK : P2P_W1C_MASK;

   generate
      if (AW != CFG_AW) begin : g_aw_chk
         $error("bcfg_bank: AW must match package address width");
      end
      if (DW != CFG_DW) begin : g_dw_chk
         $error("bcfg_bank: DW must match package data width");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic          pol_ok;
   logic [DW-1:0] pol_byte;
   logic          wr_commit;
   logic          sts_hit;
   logic [DW-1:0] sts_base;

   bcfg_wpolicy #(.FUNC_ID(FUNC_ID)) u_pol (
      .addr      (addr),
      .cur_byte  (mem[addr]),
      .wdata     (wdata),
      .wr_ok     (pol_ok),
      .next_byte (pol_byte)
   );

   assign wr_commit = wr_en && pol_ok;
   assign sts_hit   = wr_commit && (addr == A_STS);
   // set events are merged after any clear in the same cycle, so set wins
   assign sts_base  = sts_hit ? pol_byte : mem[A_STS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= reset_value(FUNC_ID, addr_t'(i));
         end
      end else begin
         if (wr_commit) begin
            mem[addr] <= pol_byte;
         end
         if (|(sts_set & W1C_MASK)) begin
            mem[A_STS] <= sts_base | (sts_set & W1C_MASK);
         end
      end
   end

   assign rd_byte = mem[addr];

   generate
      if (FUNC_ID == 0) begin : g_shadow
         assign shadow[0] = mem[A_SHD0];
         assign shadow[1] = mem[A_SHD1];
         assign shadow[2] = mem[A_SHD2];
      end else begin : g_no_shadow
         for (genvar s = 0; s < NUM_SHADOW; s++) begin : g_zero
            assign shadow[s] = '0;
         end
      end
   endgenerate

endmodule

// File: rtl/bcfg_regfile.sv
module bcfg_regfile
   import bcfg_pkg::*;
#(
   parameter int unsigned FUNC_W   = 3,
   parameter int unsigned NUM_FUNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FUNC_W-1:0] cfg_func,
   input  logic [7:0]        cfg_addr,
   input  logic              cfg_wr,
   input  logic [7:0]        cfg_wdata,
   input  logic [7:0]        host_sts_set,
   input  logic [7:0]        p2p_sts_set,
   output logic [7:0]        cfg_rdata,
   output logic [7:0]        shadow_ctl0,
   output logic [7:0]        shadow_ctl1,
   output logic [7:0]        shadow_ctl2
);

   localparam int unsigned SEL_W    = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1;
   localparam byte_t       MISS_VAL = 8'hFF;

   generate
      if (NUM_FUNC != 2) begin : g_nf_chk
         $error("bcfg_regfile: exactly two functions are supported");
      end
      if (FUNC_W < SEL_W) begin : g_fw_chk
         $error("bcfg_regfile: FUNC_W too narrow for NUM_FUNC");
      end
   endgenerate

   logic [7:0] bank_rd  [NUM_FUNC];
   logic [7:0] bank_shd [NUM_FUNC][NUM_SHADOW];
   logic [7:0] bank_sts [NUM_FUNC];
   logic       func_ok;

   assign bank_sts[0] = host_sts_set;
   assign bank_sts[1] = p2p_sts_set;
   assign func_ok     = (cfg_func < FUNC_W'(NUM_FUNC));

   generate
      for (genvar f = 0; f < NUM_FUNC; f++) begin : g_bank
         logic sel;
         assign sel = (cfg_func == FUNC_W'(f));

         bcfg_bank #(
            .FUNC_ID (f),
            .AW      (CFG_AW),
            .DW      (CFG_DW)
         ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_wr && sel),
            .addr    (cfg_addr),
            .wdata   (cfg_wdata),
            .sts_set (bank_sts[f]),
            .rd_byte (bank_rd[f]),
            .shadow  (bank_shd[f])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_rdata <= '0;
      end else if (func_ok) begin
         cfg_rdata <= bank_rd[cfg_func[SEL_W-1:0]];
      end else begin
         cfg_rdata <= MISS_VAL;
      end
   end

   // banks without shadow bytes drive zero, so an OR-merge is exact
   always_comb begin
      shadow_ctl0 = '0;
      shadow_ctl1 = '0;
      shadow_ctl2 = '0;
      for (int f = 0; f < NUM_FUNC; f++) begin
         shadow_ctl0 = shadow_ctl0 | bank_shd[f][0];
         shadow_ctl1 = shadow_ctl1 | bank_shd[f][1];
         shadow_ctl2 = shadow_ctl2 | bank_shd[f][2];
      end
   end

endmodule

// File: rtl/bcfg_regfile_chk.sv
module bcfg_regfile_chk #(
   parameter int unsigned FUNC_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [FUNC_W-1:0] cfg_func,
   input logic [7:0]        cfg_addr,
   input logic              cfg_wr,
   input logic [7:0]        cfg_rdata,
   input logic [7:0]        shadow_ctl0,
   input logic [7:0]        shadow_ctl1,
   input logic [7:0]        shadow_ctl2
);

   logic f0, f1, shd_wr;
   assign f0     = (cfg_func == FUNC_W'(0));
   assign f1     = (cfg_func == FUNC_W'(1));
   assign shd_wr = cfg_wr && f0 && (cfg_addr inside {8'h61, 8'h62, 8'h63});

   p_bad_func_ff_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(f0 || f1) |=> (cfg_rdata == 8'hFF));

   p_host_cmd_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (f0 && cfg_addr == 8'h04) |=> ((cfg_rdata & ~8'h40) == 8'h00));

   p_p2p_cmd_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (f1 && cfg_addr == 8'h04) |=> ((cfg_rdata & ~8'h47) == 8'h00));

   p_host_sts_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (f0 && cfg_addr == 8'h07) |=> ((cfg_rdata & ~8'hB0) == 8'h00));

   p_p2p_sts_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (f1 && cfg_addr == 8'h07) |=> ((cfg_rdata & ~8'h30) == 8'h00));

   p_host_aper_nib_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (f0 && cfg_addr == 8'h12) |=> (cfg_rdata[3:0] == 4'h0));

   p_p2p_window_nib_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (f1 && (cfg_addr inside {8'h20, 8'h22, 8'h24, 8'h26})) |=> (cfg_rdata[3:0] == 4'h0));

   p_shadow_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (f0 && cfg_addr == 8'h61) |=> (cfg_rdata == $past(shadow_ctl0)));

   p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !shd_wr |=> ($stable(shadow_ctl0) && $stable(shadow_ctl1) && $stable(shadow_ctl2)));

endmodule

bind bcfg_regfile bcfg_regfile_chk #(.FUNC_W(FUNC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_func    (cfg_func),
   .cfg_addr    (cfg_addr),
   .cfg_wr      (cfg_wr),
   .cfg_rdata   (cfg_rdata),
   .shadow_ctl0 (shadow_ctl0),
   .shadow_ctl1 (shadow_ctl1),
   .shadow_ctl2 (shadow_ctl2)
);

// File: tb/bcfg_regfile_tb_top.sv
module bcfg_regfile_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] cfg_func;
   logic [7:0] cfg_addr;
   logic       cfg_wr;
   logic [7:0] cfg_wdata;
   logic [7:0] host_sts_set;
   logic [7:0] p2p_sts_set;
   logic [7:0] cfg_rdata;
   logic [7:0] shadow_ctl0, shadow_ctl1, shadow_ctl2;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bcfg_regfile dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_func     (cfg_func),
      .cfg_addr     (cfg_addr),
      .cfg_wr       (cfg_wr),
      .cfg_wdata    (cfg_wdata),
      .host_sts_set (host_sts_set),
      .p2p_sts_set  (p2p_sts_set),
      .cfg_rdata    (cfg_rdata),
      .shadow_ctl0  (shadow_ctl0),
      .shadow_ctl1  (shadow_ctl1),
      .shadow_ctl2  (shadow_ctl2)
   );

   task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   task automatic do_write(logic [2:0] f, logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      cfg_func = f; cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic do_read(logic [2:0] f, logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      cfg_func = f; cfg_addr = a; cfg_wr = 1'b0;
      @(negedge clk);
      d = cfg_rdata;
   endtask

   task automatic wr_rd(string req, logic [2:0] f, logic [7:0] a, logic [7:0] d, logic [7:0] exp);
      logic [7:0] got;
      do_write(f, a, d);
      do_read(f, a, got);
      check(req, $sformatf("f%0d addr %02h", f, a), got, exp);
   endtask

   task automatic t_reset_r7();
      logic [7:0] got;
      check("R7", "rdata after reset", cfg_rdata, 8'h00);
      check("R7", "shadow0 reset", shadow_ctl0, 8'h00);
      do_read(3'd1, 8'h25, got); check("R7", "f1 25", got, 8'hFF);
      do_read(3'd1, 8'h24, got); check("R7", "f1 24", got, 8'h00);
      do_read(3'd0, 8'h63, got); check("R7", "f0 63", got, 8'h00);
   endtask

   task automatic t_bad_func_r1();
      logic [7:0] got;
      do_read(3'd2, 8'h00, got); check("R1", "func2 read", got, 8'hFF);
      do_read(3'd7, 8'h61, got); check("R1", "func7 read", got, 8'hFF);
      do_write(3'd2, 8'h61, 8'h55);
      check("R1", "shadow0 after func2 write", shadow_ctl0, 8'h00);
      do_read(3'd0, 8'h61, got); check("R1", "f0 61 untouched", got, 8'h00);
      do_write(3'd3, 8'h50, 8'h77);
      do_read(3'd1, 8'h50, got); check("R1", "f1 50 untouched", got, 8'h00);
   endtask

   task automatic t_host_ro_r2();
      logic [7:0] ro [9] = '{8'h00, 8'h05, 8'h0C, 8'h11, 8'h4F, 8'h79, 8'h87, 8'hA7, 8'hFC};
      logic [7:0] rw [9] = '{8'h0D, 8'h13, 8'h50, 8'h78, 8'h7E, 8'h84, 8'h88, 8'hA8, 8'hFD};
      foreach (ro[i]) wr_rd("R2", 3'd0, ro[i], 8'hA5, 8'h00);
      foreach (rw[i]) wr_rd("R10", 3'd0, rw[i], 8'h5A, 8'h5A);
   endtask

   task automatic t_p2p_ro_r3();
      logic [7:0] ro [9] = '{8'h03, 8'h06, 8'h17, 8'h1B, 8'h1E, 8'h1F, 8'h3D, 8'h43, 8'hFF};
      logic [7:0] rw [6] = '{8'h18, 8'h1A, 8'h1C, 8'h27, 8'h3E, 8'h42};
      foreach (ro[i]) wr_rd("R3", 3'd1, ro[i], 8'hC3, 8'h00);
      foreach (rw[i]) wr_rd("R10", 3'd1, rw[i], 8'h3C, 8'h3C);
   endtask

   task automatic t_cmd_r4();
      wr_rd("R4", 3'd0, 8'h04, 8'hFF, 8'h40);
      wr_rd("R4", 3'd0, 8'h04, 8'hBF, 8'h00);
      wr_rd("R4", 3'd1, 8'h04, 8'hFF, 8'h47);
      wr_rd("R4", 3'd1, 8'h04, 8'hFA, 8'h42);
   endtask

   task automatic pulse_set(logic [7:0] h, logic [7:0] p);
      @(negedge clk);
      host_sts_set = h; p2p_sts_set = p;
      @(negedge clk);
      host_sts_set = '0; p2p_sts_set = '0;
   endtask

   task automatic t_status_r5();
      logic [7:0] got;
      pulse_set(8'hFF, 8'hFF);
      do_read(3'd0, 8'h07, got); check("R5", "f0 sts after set", got, 8'hB0);
      do_read(3'd1, 8'h07, got); check("R5", "f1 sts after set", got, 8'h30);
      wr_rd("R5", 3'd0, 8'h07, 8'h10, 8'hA0);
      wr_rd("R5", 3'd0, 8'h07, 8'h4F, 8'hA0);
      wr_rd("R5", 3'd0, 8'h07, 8'hFF, 8'h00);
      wr_rd("R5", 3'd1, 8'h07, 8'h20, 8'h10);
      // set and clear of bit 7 in the same cycle
      @(negedge clk);
      cfg_func = 3'd0; cfg_addr = 8'h07; cfg_wdata = 8'h80; cfg_wr = 1'b1;
      host_sts_set = 8'h80;
      @(negedge clk);
      cfg_wr = 1'b0; host_sts_set = '0;
      do_read(3'd0, 8'h07, got); check("R5", "set beats clear", got, 8'h80);
   endtask

   task automatic t_window_r6();
      wr_rd("R6", 3'd0, 8'h12, 8'hFF, 8'hF0);
      wr_rd("R6", 3'd0, 8'h13, 8'hFF, 8'hFF);
      wr_rd("R6", 3'd1, 8'h20, 8'h9C, 8'h90);
      wr_rd("R6", 3'd1, 8'h22, 8'h9C, 8'h90);
      wr_rd("R6", 3'd1, 8'h24, 8'h9C, 8'h90);
      wr_rd("R6", 3'd1, 8'h26, 8'h9C, 8'h90);
      wr_rd("R6", 3'd1, 8'h21, 8'h9C, 8'h9C);
   endtask

   task automatic t_read_timing_r8();
      logic [7:0] got;
      @(negedge clk);
      cfg_func = 3'd0; cfg_addr = 8'h50; cfg_wdata = 8'h11; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      check("R8", "same-cycle read returns old", cfg_rdata, 8'h5A);
      do_read(3'd0, 8'h50, got); check("R8", "read after write", got, 8'h11);
   endtask

   task automatic t_shadow_r9();
      do_write(3'd0, 8'h61, 8'h3C);
      check("R9", "shadow0", shadow_ctl0, 8'h3C);
      do_write(3'd0, 8'h62, 8'hC3);
      check("R9", "shadow1", shadow_ctl1, 8'hC3);
      do_write(3'd0, 8'h63, 8'h30);
      check("R9", "shadow2", shadow_ctl2, 8'h30);
      do_write(3'd1, 8'h61, 8'hEE);
      check("R9", "f1 write leaves shadow0", shadow_ctl0, 8'h3C);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_func = '0; cfg_addr = '0; cfg_wr = 1'b0; cfg_wdata = '0;
      host_sts_set = '0; p2p_sts_set = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_r7();
      t_bad_func_r1();
      t_host_ro_r2();
      t_p2p_ro_r3();
      t_cmd_r4();
      t_status_r5();
      t_window_r6();
      t_read_timing_r8();
      t_shadow_r9();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule